// File: doc/BRIEF.md
# Offered-Load Packet Traffic Generator

This block is a synthetic traffic source for a mesh network port. It produces packets of a programmable length L, in flits, with an idle gap of G cycles between consecutive packets. The offered load is therefore L/(L+G). Each packet starts with a header flit that carries a destination chosen by a 16-bit pseudo-random sequence and the source's own coordinates. Payload flits follow, and the last flit of the packet is marked as end of packet.

Flits leave through a valid/ready handshake, at most one per cycle. The block counts accepted flits and accepted packets. Length and gap are sampled when a packet starts. Stalls caused by the receiver never shorten or lengthen the programmed gap, because the gap counter starts only once the final flit has been accepted. Dropping the enable input halts injection at the next packet boundary.

Top module: `traffic_gen`

## Requirements
- R1: After reset, `out_valid` is low and both `pkt_count` and `flit_count` are zero.
- R2: The header is the first flit of a packet. Bits [3:0] hold destination X, bits [7:4] destination Y, bits [11:8] `src_x` and bits [15:12] `src_y`. All higher bits are zero.
- R3: A packet has exactly L flits, where L is `pkt_len` sampled at packet start and a value of 0 is treated as 1. `out_eop` is high only on flit L.
- R4: In a payload flit, bits [15:0] carry a sequence number. It starts at 0 after reset and rises by one for every accepted payload flit. Bits [23:16] carry the flit's index within its packet, with the header at index 0.
- R5: While enable stays high, exactly G cycles with `out_valid` low separate the cycle in which the end-of-packet flit is accepted from the next header. G is `gap_len` sampled at packet start. With G = 0 the next header is offered in the very next cycle.
- R6: While `out_valid` is high and `out_ready` is low, the flit is held: in the next cycle `out_valid` stays high and `out_data` and `out_eop` are unchanged.
- R7: Destinations come from a 16-bit shift register seeded with 0xACE1. Each step shifts left and feeds in bit15^bit13^bit12^bit10. Each packet takes one step, and X is bits [3:0] and Y is bits [7:4] of the new value. If those bits equal the source coordinates, the register takes one more step and that value is used instead.
- R8: `flit_count` rises by one for each accepted flit and `pkt_count` by one for each accepted end-of-packet flit. Each update is visible in the cycle after the handshake.
- R9: With enable low, no new packet begins. A packet already started is sent to its end.
- R10: Changing `pkt_len` or `gap_len` while a packet is in flight has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new packets to start |
| pkt_len | input | 8 | Packet length L in flits |
| gap_len | input | 8 | Idle cycles G between packets |
| src_x | input | 4 | Own X coordinate |
| src_y | input | 4 | Own Y coordinate |
| out_valid | output | 1 | Flit offered |
| out_ready | input | 1 | Receiver accepts flit |
| out_data | output | 32 | Flit content |
| out_eop | output | 1 | Last flit of packet |
| pkt_count | output | 32 | Accepted packets |
| flit_count | output | 32 | Accepted flits |

## Verification
The first header appears one cycle after enable is seen high in the idle state. Every later header appears G+1 cycles after the clock edge that accepts the previous end-of-packet flit. The counters change one edge after a handshake. The bench drives inputs just after the rising edge and samples on the falling edge, so a handshake it sees at a falling edge is the one taken at the following rising edge. It counts idle cycles between handshakes to check the gap. It compares the counters only after the output has been idle for many cycles, so no update can still be in flight.

// File: rtl/traffic_gen.sv
module traffic_gen #(
  parameter int FLIT_W  = 32,
  parameter int COORD_W = 4,
  parameter int LEN_W   = 8,
  parameter int GAP_W   = 8,
  parameter int SEQ_W   = 16,
  parameter int CNT_W   = 32,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [LEN_W-1:0]   pkt_len,
  input  logic [GAP_W-1:0]   gap_len,
  input  logic [COORD_W-1:0] src_x,
  input  logic [COORD_W-1:0] src_y,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [FLIT_W-1:0]  out_data,
  output logic               out_eop,
  output logic [CNT_W-1:0]   pkt_count,
  output logic [CNT_W-1:0]   flit_count
);
  localparam int DST_W = 2 * COORD_W;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GAP} st_t;

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  st_t              st;
  logic [15:0]      lfsr;
  logic [DST_W-1:0] dst;
  logic [LEN_W-1:0] len_q, idx;
  logic [GAP_W-1:0] gap_q, gap_cnt;
  logic [SEQ_W-1:0] seq;

  logic [15:0]      cand1, cand2, pick;
  logic [LEN_W-1:0] len_eff;
  logic             fire, last, go;

  assign cand1   = step(lfsr);
  assign cand2   = step(cand1);
  assign pick    = (cand1[DST_W-1:0] == {src_y, src_x}) ? cand2 : cand1;
  assign len_eff = (pkt_len == '0) ? LEN_W'(1) : pkt_len;

  assign out_valid = (st == S_SEND);
  assign fire      = out_valid && out_ready;
  assign last      = (idx == len_q - LEN_W'(1));
  assign out_eop   = out_valid && last;

  assign go = enable && ((st == S_IDLE) ||
                         (st == S_GAP  && gap_cnt == GAP_W'(1)) ||
                         (st == S_SEND && fire && last && gap_q == '0));

  always_comb begin
    out_data = '0;
    if (idx == '0) begin
      out_data[DST_W-1:0]         = dst;
      out_data[DST_W +: DST_W]    = {src_y, src_x};
    end else begin
      out_data[SEQ_W-1:0]         = seq;
      out_data[SEQ_W +: LEN_W]    = idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      lfsr       <= SEED;
      dst        <= '0;
      len_q      <= LEN_W'(1);
      idx        <= '0;
      gap_q      <= '0;
      gap_cnt    <= '0;
      seq        <= '0;
      pkt_count  <= '0;
      flit_count <= '0;
    end else begin
      if (fire) begin
        flit_count <= flit_count + CNT_W'(1);
        if (idx != '0) seq <= seq + SEQ_W'(1);
        if (last) pkt_count <= pkt_count + CNT_W'(1);
      end
      if (go) begin
        st    <= S_SEND;
        lfsr  <= pick;
        dst   <= pick[DST_W-1:0];
        len_q <= len_eff;
        gap_q <= gap_len;
        idx   <= '0;
      end else begin
        case (st)
          S_SEND: if (fire) begin
            if (last) begin
              if (gap_q == '0) st <= S_IDLE;
              else begin
                st      <= S_GAP;
                gap_cnt <= gap_q;
              end
            end else idx <= idx + LEN_W'(1);
          end
          S_GAP: begin
            if (gap_cnt == GAP_W'(1)) st <= S_IDLE;
            else gap_cnt <= gap_cnt - GAP_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop)));

  assert_flit_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (flit_count == $past(flit_count) + CNT_W'(1)));

  assert_pkt_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fire && out_eop) |=> $stable(pkt_count));

  assert_gap_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_eop && gap_q != '0) |=> !out_valid);

  assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !enable) |=> !out_valid);
endmodule

// File: tb/tb_traffic_gen.sv
module tb_traffic_gen;
  logic        clk = 0, rst_n = 0, enable = 0, out_ready = 1;
  logic [7:0]  pkt_len = 8'd5, gap_len = 8'd0;
  logic [3:0]  src_x = 4'd3, src_y = 4'd12;
  logic        out_valid, out_eop;
  logic [31:0] out_data, pkt_count, flit_count;

  traffic_gen dut (.clk, .rst_n, .enable, .pkt_len, .gap_len, .src_x, .src_y,
                   .out_valid, .out_ready, .out_data, .out_eop, .pkt_count, .flit_count);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit bp = 0;
  logic [7:0] rpat = 8'h5B;
  int exp_len = 5, exp_gap = 0, cur_len = 1;
  int mon_fidx = 0, mon_pkts = 0, mon_flits = 0, mon_last_len = 0, idle = 0;
  bit after_eop = 0, stall_prev = 0, prev_eop = 0;
  logic [31:0] prev_data;
  logic [15:0] mlfsr = 16'hACE1, mseq = 0;

  // fields: pkt_len[16:9], gap_len[8:1], backpressure[0]
  localparam logic [16:0] VEC [7] = '{
    {8'd5, 8'd0, 1'b0}, {8'd5, 8'd3, 1'b0}, {8'd1, 8'd2, 1'b0}, {8'd0, 8'd2, 1'b0},
    {8'd3, 8'd0, 1'b1}, {8'd5, 8'd4, 1'b1}, {8'd2, 8'd1, 1'b1}};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nx(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  always @(posedge clk) begin
    cycles++;
    #2;
    rpat = {rpat[6:0], rpat[7] ^ rpat[5] ^ rpat[4] ^ rpat[3]};
    out_ready = bp ? rpat[0] : 1'b1;
  end

  always @(posedge clk) if (cycles >= 150000) begin
    chk(0, "watchdog", cycles, 150000);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(negedge clk) if (rst_n) begin
    if (stall_prev)
      chk(out_valid && out_data == prev_data && out_eop == prev_eop, "R6 hold", out_data, prev_data);
    stall_prev = out_valid && !out_ready;
    prev_data  = out_data;
    prev_eop   = out_eop;
    if (out_valid && out_ready) begin
      if (mon_fidx == 0) begin
        logic [15:0] c1, c2;
        cur_len = exp_len;
        c1 = nx(mlfsr);
        c2 = nx(c1);
        mlfsr = (c1[7:0] == {src_y, src_x}) ? c2 : c1;
        chk(out_data == {16'd0, src_y, src_x, mlfsr[7:0]}, "R2/R7 header", out_data, {16'd0, src_y, src_x, mlfsr[7:0]});
        if (after_eop) chk(idle == exp_gap, "R5 gap", idle, exp_gap);
      end else begin
        chk(out_data == {8'd0, 8'(mon_fidx), mseq}, "R4 payload", out_data, {8'd0, 8'(mon_fidx), mseq});
        mseq++;
      end
      chk(out_eop == (mon_fidx == cur_len - 1), "R3 eop", out_eop, mon_fidx == cur_len - 1);
      mon_flits++;
      if (out_eop) begin
        mon_pkts++;
        mon_last_len = mon_fidx + 1;
        mon_fidx = 0;
        idle = 0;
        after_eop = 1;
      end else mon_fidx++;
    end else if (!out_valid) idle++;
  end

  task automatic start(input int l, input int g, input bit b);
    @(posedge clk); #2;
    pkt_len = 8'(l); gap_len = 8'(g); bp = b;
    exp_len = (l == 0) ? 1 : l; exp_gap = g;
    after_eop = 0;
    enable = 1;
  endtask

  task automatic stop_and_check(input string why);
    @(posedge clk); #2 enable = 0;
    repeat (80) @(negedge clk);
    chk(!out_valid, "R9 stopped", out_valid, 0);
    chk(mon_fidx == 0, "R9 boundary", mon_fidx, 0);
    chk(pkt_count == mon_pkts, "R8 pkt_count", pkt_count, mon_pkts);
    chk(flit_count == mon_flits, "R8 flit_count", flit_count, mon_flits);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!out_valid && pkt_count == 0 && flit_count == 0, "R1 reset", {out_valid, pkt_count}, 0);
    repeat (10) @(negedge clk);
    chk(!out_valid, "R9 disabled idle", out_valid, 0);

    // first packet exercises the source-collision skip of R7 (0x59C3 -> 0xB387)
    for (int i = 0; i < 7; i++) begin
      int target;
      start(VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      target = mon_pkts + 6;
      while (mon_pkts < target) @(negedge clk);
      stop_and_check("vector");
    end

    // R10: config change in flight
    start(5, 6, 0);
    while (mon_fidx != 1) @(negedge clk);
    @(posedge clk); #2 pkt_len = 8'd2; gap_len = 8'd1; exp_len = 2;
    while (mon_fidx != 0) @(negedge clk);
    chk(mon_last_len == 5, "R10 length kept", mon_last_len, 5);
    while (mon_fidx == 0) @(negedge clk);
    exp_gap = 1;
    while (mon_fidx != 0) @(negedge clk);
    chk(mon_last_len == 2, "R10 new length", mon_last_len, 2);
    stop_and_check("r10");

    // R9: drop enable mid-packet
    start(5, 0, 1);
    while (mon_fidx != 2) @(negedge clk);
    @(posedge clk); #2 enable = 0;
    repeat (60) @(negedge clk);
    chk(mon_last_len == 5 && mon_fidx == 0, "R9 finish packet", mon_last_len, 5);
    chk(!out_valid, "R9 no restart", out_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule